// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit Addressing

This block is the 128-byte internal data store of a small 8-bit controller core. Three access ports share one storage array. A byte port reads and writes any location. It takes either a direct 7-bit address or an indirect address held in pointer register 0 or pointer register 1 of the active bank. A register port names one of eight working registers. The block translates that register number through a two-bit bank select into the lowest 32 bytes, which hold four banks of eight registers each.

A bit port reads and writes single bits. It uses an 8-bit bit address. Bit addresses below 80H fall in a 16-byte window starting at byte 20H. Bit addresses of 80H and above belong to the special-function area outside this block, so they are passed straight out to an external port, and the read bit is taken from that port.

Reads are combinational from the stored contents. Writes take effect at the rising clock edge. When two ports write the same byte in one cycle, a fixed priority decides which write is kept.

Top module: `iram_bank_bit`

## Requirements
- R1: A synchronous active-low reset clears all 128 bytes to 00H.
- R2: Register n (0..7) of the register port maps to byte address {bank_sel[1:0], n[2:0]}. `reg_rdata` shows that byte in the same cycle. A write through `reg_we` is visible after the next rising edge.
- R3: With `dir_indirect`=0, the byte port uses `dir_addr` as the byte address. `dir_rdata` shows that byte in the same cycle. A write through `dir_we` is visible after the next rising edge.
- R4: With `dir_indirect`=1, the byte address is the low 7 bits of the active-bank register selected by `dir_ptr_sel` (0 selects byte {bank_sel,000}, 1 selects byte {bank_sel,001}). Bit 7 of the pointer value is ignored.
- R5: A bit address b with b[7]=0 selects bit b[2:0] of byte 20H+b[6:3]. `bit_rdata` shows that bit in the same cycle.
- R6: An internal bit write changes only the addressed bit of its byte. The change is visible after one rising edge.
- R7: A bit address with b[7]=1 raises `ext_bit_sel`. It drives `ext_bit_addr`=b and `ext_bit_wdata`=`bit_wdata`. It raises `ext_bit_we` only when `bit_we` is 1, and it returns `ext_bit_rdata` on `bit_rdata`. Internal RAM is left unchanged. When b[7]=0, `ext_bit_we` stays 0.
- R8: When a byte-port write and an internal bit write hit the same byte in one cycle, the byte-port data is stored and the bit write is dropped.
- R9: When a byte-port write and a register-port write hit the same byte in one cycle, the byte-port data is stored.
- R10: Writes from different ports to different bytes in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 2 | Active register bank |
| dir_we | input | 1 | Byte-port write enable |
| dir_indirect | input | 1 | 1: address from pointer register, 0: from dir_addr |
| dir_ptr_sel | input | 1 | Pointer register choice (0 or 1) |
| dir_addr | input | 7 | Direct byte address |
| dir_wdata | input | 8 | Byte-port write data |
| dir_rdata | output | 8 | Byte-port read data |
| reg_we | input | 1 | Register-port write enable |
| reg_num | input | 3 | Register number 0..7 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| bit_we | input | 1 | Bit write enable |
| bit_addr | input | 8 | Bit address |
| bit_wdata | input | 1 | Bit write value |
| bit_rdata | output | 1 | Bit read value |
| ext_bit_sel | output | 1 | Bit address is in the external area |
| ext_bit_we | output | 1 | External bit write strobe |
| ext_bit_addr | output | 8 | Bit address passed out |
| ext_bit_wdata | output | 1 | Bit write value passed out |
| ext_bit_rdata | input | 1 | Bit value returned from the external area |

## Verification
All three read results and the external pass-through signals depend only on the current inputs and the stored bytes, so they are due in the same cycle as the stimulus. The bench samples them one time unit after driving inputs on the falling edge. A write of any kind appears only after the next rising edge. The bench therefore updates its reference model at that edge, applying the port priority, and the following cycle's reads check the new contents. Reset is checked by reading back every address in the first cycles after reset is released.

// File: rtl/iram_pkg.sv
// Package: shared constants and helpers for the banked internal RAM.
// Assumes byte-wide storage; bit indices address bits inside one byte.
package iram_pkg;

    localparam int unsigned IRAM_ADDR_W   = 7;
    localparam int unsigned IRAM_DATA_W   = 8;
    localparam int unsigned IRAM_REG_W    = 3;
    localparam int unsigned IRAM_BANK_W   = 2;
    localparam int unsigned IRAM_BIT_BASE = 32;

    // Write source, listed from lowest to highest priority.
    typedef enum logic [1:0] {
        WSRC_NONE = 2'd0,
        WSRC_BIT  = 2'd1,
        WSRC_REG  = 2'd2,
        WSRC_BYTE = 2'd3
    } wsrc_e;

    // Return a byte with one bit replaced.
    function automatic logic [IRAM_DATA_W-1:0] put_bit(
        input logic [IRAM_DATA_W-1:0]         old_byte,
        input logic [$clog2(IRAM_DATA_W)-1:0] idx,
        input logic                           val
    );
        logic [IRAM_DATA_W-1:0] res;
        res      = old_byte;
        res[idx] = val;
        return res;
    endfunction

endpackage

// File: rtl/iram_xlate.sv
// Address translation: register numbers to bank bytes, pointer register
// location, and bit address to byte plus bit index.
// Assumes the banks sit at byte 0 upward and the bit window holds
// 2**(ADDR_W-IDX_W) bytes starting at BIT_BASE.
module iram_xlate #(
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned REG_W    = 3,
    parameter int unsigned BANK_W   = 2,
    parameter int unsigned BIT_BASE = 32
) (
    input  logic [BANK_W-1:0]          bank_sel,
    input  logic [REG_W-1:0]           reg_num,
    input  logic                       ptr_sel,
    input  logic [ADDR_W:0]            bit_addr,
    output logic [ADDR_W-1:0]          reg_byte,
    output logic [ADDR_W-1:0]          ptr_byte,
    output logic [ADDR_W-1:0]          bit_byte,
    output logic [$clog2(DATA_W)-1:0]  bit_idx,
    output logic                       bit_ext
);
    localparam int unsigned IDX_W  = $clog2(DATA_W);
    localparam int unsigned BANK_SPAN = BANK_W + REG_W;
    localparam int unsigned PAD_W  = ADDR_W - BANK_SPAN;
    localparam int unsigned WIN_W  = ADDR_W - IDX_W;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BIT_BASE);

    // Register number to bank byte.
    always_comb begin
        reg_byte = {{PAD_W{1'b0}}, bank_sel, reg_num};
    end

    // Location of pointer register 0 or 1 of the active bank.
    always_comb begin
        ptr_byte = {{PAD_W{1'b0}}, bank_sel, {(REG_W-1){1'b0}}, ptr_sel};
    end

    // Bit address split into window byte and bit index.
    always_comb begin
        bit_ext  = bit_addr[ADDR_W];
        bit_idx  = bit_addr[IDX_W-1:0];
        bit_byte = BASE_A + {{IDX_W{1'b0}}, bit_addr[ADDR_W-1:IDX_W]};
    end

    // The window must fit below the top of the address space.
    initial begin
        if (BIT_BASE + (1 << WIN_W) > (1 << ADDR_W))
            $display("iram_xlate: bit window exceeds address space");
    end

endmodule

// File: rtl/iram_store.sv
// Storage array with combinational read ports and three prioritised
// write requests: byte port over register port over bit write.
// Assumes write addresses are already translated; the bit write is a
// read-modify-write of the current byte contents.
module iram_store #(
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RD_PORTS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         raddr [RD_PORTS],
    output logic [DATA_W-1:0]         rdata [RD_PORTS],
    input  logic                      byte_we,
    input  logic [ADDR_W-1:0]         byte_waddr,
    input  logic [DATA_W-1:0]         byte_wdata,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_waddr,
    input  logic [DATA_W-1:0]         reg_wdata,
    input  logic                      bit_we,
    input  logic [ADDR_W-1:0]         bit_waddr,
    input  logic [$clog2(DATA_W)-1:0] bit_widx,
    input  logic                      bit_wval
);
    import iram_pkg::*;

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] bit_merged;

    // Combinational read ports.
    for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

    // Byte with the addressed bit replaced.
    always_comb begin
        bit_merged = put_bit(mem[bit_waddr], bit_widx, bit_wval);
    end

    // Per-byte write selection and update.
    for (genvar a = 0; a < DEPTH; a++) begin : g_cell
        wsrc_e src;

        // Pick the highest-priority writer that targets this byte.
        always_comb begin
            if (byte_we && byte_waddr == ADDR_W'(a))
                src = WSRC_BYTE;
            else if (reg_we && reg_waddr == ADDR_W'(a))
                src = WSRC_REG;
            else if (bit_we && bit_waddr == ADDR_W'(a))
                src = WSRC_BIT;
            else
                src = WSRC_NONE;
        end

        // Store the chosen data, or clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[a] <= '0;
            else begin
                case (src)
                    WSRC_BYTE: mem[a] <= byte_wdata;
                    WSRC_REG:  mem[a] <= reg_wdata;
                    WSRC_BIT:  mem[a] <= bit_merged;
                    default:   mem[a] <= mem[a];
                endcase
            end
        end
    end

endmodule

// File: rtl/iram_bitio.sv
// Bit port steering: internal bit read and write qualification, and
// pass-through of external-area bit accesses.
// Assumes bit_ext is the top bit of the bit address.
module iram_bitio #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic                      bit_ext,
    input  logic                      bit_we,
    input  logic                      bit_wdata,
    input  logic [ADDR_W:0]           bit_addr,
    input  logic [DATA_W-1:0]         win_byte,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  logic                      ext_rdata,
    output logic                      int_we,
    output logic                      bit_rdata,
    output logic                      ext_sel,
    output logic                      ext_we,
    output logic [ADDR_W:0]           ext_addr,
    output logic                      ext_wdata
);
    // Route writes either inside the RAM or out to the external area.
    always_comb begin
        int_we    = bit_we & ~bit_ext;
        ext_we    = bit_we &  bit_ext;
        ext_sel   = bit_ext;
        ext_addr  = bit_addr;
        ext_wdata = bit_wdata;
    end

    // Select the read bit from the window byte or the external area.
    always_comb begin
        bit_rdata = bit_ext ? ext_rdata : win_byte[bit_idx];
    end

endmodule

// File: rtl/iram_bank_bit.sv
// Top: banked internal data RAM with byte, register and bit ports.
// Assumes reads are combinational and all writes land on the rising
// edge; byte port beats register port beats bit write on a shared byte.
module iram_bank_bit #(
    parameter int unsigned ADDR_W   = iram_pkg::IRAM_ADDR_W,
    parameter int unsigned DATA_W   = iram_pkg::IRAM_DATA_W,
    parameter int unsigned REG_W    = iram_pkg::IRAM_REG_W,
    parameter int unsigned BANK_W   = iram_pkg::IRAM_BANK_W,
    parameter int unsigned BIT_BASE = iram_pkg::IRAM_BIT_BASE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BANK_W-1:0]   bank_sel,
    input  logic                dir_we,
    input  logic                dir_indirect,
    input  logic                dir_ptr_sel,
    input  logic [ADDR_W-1:0]   dir_addr,
    input  logic [DATA_W-1:0]   dir_wdata,
    output logic [DATA_W-1:0]   dir_rdata,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_num,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                bit_we,
    input  logic [ADDR_W:0]     bit_addr,
    input  logic                bit_wdata,
    output logic                bit_rdata,
    output logic                ext_bit_sel,
    output logic                ext_bit_we,
    output logic [ADDR_W:0]     ext_bit_addr,
    output logic                ext_bit_wdata,
    input  logic                ext_bit_rdata
);
    localparam int unsigned IDX_W    = $clog2(DATA_W);
    localparam int unsigned RD_PORTS = 4;
    localparam int unsigned RP_PTR   = 0;
    localparam int unsigned RP_DIR   = 1;
    localparam int unsigned RP_REG   = 2;
    localparam int unsigned RP_BIT   = 3;

    logic [ADDR_W-1:0] reg_byte, ptr_byte, bit_byte, dir_byte;
    logic [IDX_W-1:0]  bit_idx;
    logic              bit_ext, bit_int_we;
    logic [ADDR_W-1:0] raddr [RD_PORTS];
    logic [DATA_W-1:0] rdata [RD_PORTS];

    iram_xlate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
        .BANK_W(BANK_W), .BIT_BASE(BIT_BASE)
    ) xlate_i (
        .bank_sel (bank_sel),
        .reg_num  (reg_num),
        .ptr_sel  (dir_ptr_sel),
        .bit_addr (bit_addr),
        .reg_byte (reg_byte),
        .ptr_byte (ptr_byte),
        .bit_byte (bit_byte),
        .bit_idx  (bit_idx),
        .bit_ext  (bit_ext)
    );

    // Effective byte-port address: direct, or low bits of the pointer.
    always_comb begin
        dir_byte = dir_indirect ? rdata[RP_PTR][ADDR_W-1:0] : dir_addr;
    end

    // Read port address assignment.
    always_comb begin
        raddr[RP_PTR] = ptr_byte;
        raddr[RP_DIR] = dir_byte;
        raddr[RP_REG] = reg_byte;
        raddr[RP_BIT] = bit_byte;
    end

    iram_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_PORTS(RD_PORTS)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .raddr      (raddr),
        .rdata      (rdata),
        .byte_we    (dir_we),
        .byte_waddr (dir_byte),
        .byte_wdata (dir_wdata),
        .reg_we     (reg_we),
        .reg_waddr  (reg_byte),
        .reg_wdata  (reg_wdata),
        .bit_we     (bit_int_we),
        .bit_waddr  (bit_byte),
        .bit_widx   (bit_idx),
        .bit_wval   (bit_wdata)
    );

    iram_bitio #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) bitio_i (
        .bit_ext   (bit_ext),
        .bit_we    (bit_we),
        .bit_wdata (bit_wdata),
        .bit_addr  (bit_addr),
        .win_byte  (rdata[RP_BIT]),
        .bit_idx   (bit_idx),
        .ext_rdata (ext_bit_rdata),
        .int_we    (bit_int_we),
        .bit_rdata (bit_rdata),
        .ext_sel   (ext_bit_sel),
        .ext_we    (ext_bit_we),
        .ext_addr  (ext_bit_addr),
        .ext_wdata (ext_bit_wdata)
    );

    // Read data outputs.
    always_comb begin
        dir_rdata = rdata[RP_DIR];
        reg_rdata = rdata[RP_REG];
    end

endmodule

// File: rtl/iram_checker.sv
// Checker: temporal properties of the banked RAM, observed at the ports.
module iram_checker #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned REG_W  = 3,
    parameter int unsigned BANK_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [BANK_W-1:0]   bank_sel,
    input logic                dir_we,
    input logic                dir_indirect,
    input logic [ADDR_W-1:0]   dir_addr,
    input logic [DATA_W-1:0]   dir_wdata,
    input logic [DATA_W-1:0]   dir_rdata,
    input logic                reg_we,
    input logic [REG_W-1:0]    reg_num,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                bit_we,
    input logic [ADDR_W:0]     bit_addr,
    input logic                bit_wdata,
    input logic                bit_rdata,
    input logic                ext_bit_we,
    input logic                ext_bit_rdata
);
    // First cycle out of reset: every read sees cleared storage.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_rdata == '0 && reg_rdata == '0 &&
                          (bit_addr[ADDR_W] || !bit_rdata)));

    // Register write without byte-port interference reads back next cycle.
    p_reg_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !dir_we) |=>
        (reg_num != $past(reg_num) || bank_sel != $past(bank_sel) ||
         reg_rdata == $past(reg_wdata)));

    // Direct byte write always reads back next cycle (byte port wins).
    p_dir_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_we && !dir_indirect) |=>
        (dir_indirect || dir_addr != $past(dir_addr) ||
         dir_rdata == $past(dir_wdata)));

    // Lone internal bit write reads back next cycle.
    p_bit_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !bit_addr[ADDR_W] && !dir_we) |=>
        (bit_addr != $past(bit_addr) || bit_rdata == $past(bit_wdata)));

    // External bit area: read value comes from outside.
    p_ext_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_addr[ADDR_W] |-> (bit_rdata == ext_bit_rdata));

    // No external strobe for an internal bit address.
    p_ext_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_addr[ADDR_W] |-> !ext_bit_we);

endmodule

bind iram_bank_bit iram_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .BANK_W(BANK_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_sel      (bank_sel),
    .dir_we        (dir_we),
    .dir_indirect  (dir_indirect),
    .dir_addr      (dir_addr),
    .dir_wdata     (dir_wdata),
    .dir_rdata     (dir_rdata),
    .reg_we        (reg_we),
    .reg_num       (reg_num),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .bit_we        (bit_we),
    .bit_addr      (bit_addr),
    .bit_wdata     (bit_wdata),
    .bit_rdata     (bit_rdata),
    .ext_bit_we    (ext_bit_we),
    .ext_bit_rdata (ext_bit_rdata)
);

// File: tb/iram_bank_bit_tb.sv
// Bench: reference model of the RAM, random and directed stimulus.
module iram_bank_bit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       dir_we = 0, dir_indirect = 0, dir_ptr_sel = 0;
    logic [6:0] dir_addr = '0;
    logic [7:0] dir_wdata = '0, dir_rdata;
    logic       reg_we = 0;
    logic [2:0] reg_num = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       bit_we = 0, bit_wdata = 0, bit_rdata;
    logic [7:0] bit_addr = '0;
    logic       ext_bit_sel, ext_bit_we, ext_bit_wdata;
    logic [7:0] ext_bit_addr;
    logic       ext_bit_rdata = 0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] model [128];

    always #5 clk = ~clk;

    iram_bank_bit dut_i (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] m_dir_addr();
        logic [6:0] p;
        p = model[{dir_ptr_sel ? 7'd1 : 7'd0} | {bank_sel, 3'd0}][6:0];
        return dir_indirect ? p : dir_addr;
    endfunction

    function automatic logic [6:0] m_reg_addr();
        return {2'b00, bank_sel, reg_num};
    endfunction

    function automatic logic [6:0] m_bit_byte();
        return 7'h20 + {3'b000, bit_addr[6:3]};
    endfunction

    // Check all outputs against the model, then apply the edge.
    task automatic step();
        logic [6:0] da, ra, bb;
        logic [7:0] nb;
        #1;
        da = m_dir_addr();
        ra = m_reg_addr();
        bb = m_bit_byte();
        chk(dir_indirect ? "R4 indirect read" : "R3 direct read", dir_rdata, model[da]);
        chk("R2 register read", reg_rdata, model[ra]);
        if (bit_addr[7]) begin
            chk("R7 ext bit read", {7'd0, bit_rdata}, {7'd0, ext_bit_rdata});
            chk("R7 ext pass", {ext_bit_sel, ext_bit_we, ext_bit_wdata, 5'd0},
                {1'b1, bit_we, bit_wdata, 5'd0});
            chk("R7 ext addr", ext_bit_addr, bit_addr);
        end else begin
            chk("R5 bit read", {7'd0, bit_rdata}, {7'd0, model[bb][bit_addr[2:0]]});
            chk("R7 ext idle", {ext_bit_sel, ext_bit_we}, 8'd0);
        end
        @(posedge clk);
        // Model write: bit, then register, then byte port (last wins).
        if (bit_we && !bit_addr[7]) begin
            nb = model[bb];
            nb[bit_addr[2:0]] = bit_wdata;
        end
        if (bit_we && !bit_addr[7]) model[bb] = nb;
        if (reg_we) model[ra] = reg_wdata;
        if (dir_we) model[da] = dir_wdata;
        @(negedge clk);
    endtask

    task automatic idle();
        dir_we = 0; reg_we = 0; bit_we = 0;
    endtask

    task automatic read_dir(input logic [6:0] a, input logic [7:0] exp, input string tag);
        idle();
        dir_indirect = 0; dir_addr = a;
        #1;
        chk(tag, dir_rdata, exp);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: every byte reads zero after reset.
        for (int i = 0; i < 128; i++) read_dir(7'(i), 8'h00, "R1 reset clear");

        // R10: three writes to different bytes in one cycle.
        bank_sel = 2'd1; reg_num = 3'd5; reg_wdata = 8'h3C; reg_we = 1;
        dir_indirect = 0; dir_addr = 7'h40; dir_wdata = 8'h99; dir_we = 1;
        bit_addr = 8'h7F; bit_wdata = 1; bit_we = 1;
        step(); idle();
        read_dir(7'h40, 8'h99, "R10 byte part");
        read_dir(7'h0D, 8'h3C, "R10 register part");
        read_dir(7'h2F, 8'h80, "R10 bit part");

        // R6: clearing one bit leaves its neighbours.
        dir_addr = 7'h25; dir_wdata = 8'hFF; dir_we = 1; step(); idle();
        bit_addr = 8'h2C; bit_wdata = 0; bit_we = 1; step(); idle();
        read_dir(7'h25, 8'hEF, "R6 single bit cleared");

        // R8: byte write beats bit write on byte 22H.
        dir_addr = 7'h22; dir_wdata = 8'hA5; dir_we = 1;
        bit_addr = 8'h10; bit_wdata = 0; bit_we = 1;
        step(); idle();
        read_dir(7'h22, 8'hA5, "R8 byte over bit");

        // R9: byte write beats register write on byte 13H.
        bank_sel = 2'd2; reg_num = 3'd3; reg_wdata = 8'h11; reg_we = 1;
        dir_addr = 7'h13; dir_wdata = 8'h77; dir_we = 1;
        step(); idle();
        read_dir(7'h13, 8'h77, "R9 byte over register");

        // R4: pointer bit 7 ignored; bank 3 R0 holds 85H, R1 holds 06H.
        bank_sel = 2'd3;
        dir_addr = 7'h18; dir_wdata = 8'h85; dir_we = 1; step();
        dir_addr = 7'h19; dir_wdata = 8'h06; dir_we = 1; step();
        dir_addr = 7'h05; dir_wdata = 8'h5A; dir_we = 1; step(); idle();
        dir_indirect = 1; dir_ptr_sel = 0;
        #1; chk("R4 pointer bit7 ignored", dir_rdata, 8'h5A);
        @(posedge clk); @(negedge clk);
        dir_ptr_sel = 1; dir_wdata = 8'hC3; dir_we = 1; step(); idle();
        read_dir(7'h06, 8'hC3, "R4 indirect write via R1");

        // R7: external bit write leaves internal byte 2AH unchanged.
        dir_indirect = 0; dir_addr = 7'h2A; dir_wdata = 8'h0F; dir_we = 1; step(); idle();
        bit_addr = 8'hD3; bit_wdata = 1; bit_we = 1; ext_bit_rdata = 1; step(); idle();
        read_dir(7'h2A, 8'h0F, "R7 internal untouched");

        // Random mix over all ports.
        for (int n = 0; n < 3000; n++) begin
            bank_sel      = 2'($urandom);
            dir_we        = ($urandom % 3) == 0;
            dir_indirect  = $urandom % 2;
            dir_ptr_sel   = $urandom % 2;
            dir_addr      = ($urandom % 2) ? 7'($urandom % 48) : 7'($urandom);
            dir_wdata     = 8'($urandom);
            reg_we        = ($urandom % 3) == 0;
            reg_num       = 3'($urandom);
            reg_wdata     = 8'($urandom);
            bit_we        = ($urandom % 2) == 0;
            bit_addr      = 8'($urandom);
            bit_wdata     = $urandom % 2;
            ext_bit_rdata = $urandom % 2;
            step();
        end
        idle();

        // R1: reset again clears written contents.
        rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        read_dir(7'h2F, 8'h00, "R1 second reset");
        read_dir(7'h40, 8'h00, "R1 second reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule